// File: doc/BRIEF.md
# Tap-Selectable Periodic Interrupt Timer

This block produces the periodic interrupt that drives a kernel scheduler. A free-running counter advances once for every rising edge of a slow tick input. The tick comes from an oscillator that has no fixed phase relation to the CPU clock. Software picks one bit of that counter through a small tap-index register. Each time the picked bit goes from 0 to 1, the block raises its interrupt output for exactly one CPU clock.

Picking tap k makes the interrupt period 2^(k+1) ticks. For example, a 50 Hz tick with tap 3 gives one pulse every 0.32 s. The timer never stops and has no enable or mask input, so it fires whatever program is running; masking is the CPU's job. Writing a new tap index never creates a spurious pulse of its own.

The tick is brought into the CPU domain through a synchronizer chain, and the count lives in the CPU domain. The asynchronous active-low reset is released in step with the CPU clock.

Top module: `ptimer_irq`

## Requirements
- R1: The counter resets to zero. It advances by exactly one for each rising edge of `tick_async_i`, however long the tick stays high.
- R2: The tap index is a TAP_W = log2(CNT_W) bit register, loaded from `tap_wdata_i` in any cycle where `tap_we_i` is 1. It resets to CNT_W-1, the most significant counter bit.
- R3: `irq_o` is never high in two consecutive CPU clock cycles.
- R4: `irq_o` pulses once for each 0-to-1 change of counter bit `tap`, and never for a 1-to-0 change. Over counts c+1..c+n, the number of pulses equals the number of values j in that range with j mod 2^(tap+1) == 2^tap.
- R5: A tap write clears the edge history. A write is followed by no pulse unless the newly selected bit later rises through counting; in particular, switching from a 0 bit to a 1 bit gives no pulse.
- R6: The counter wraps from all-ones to zero and keeps counting. The wrap itself raises no bit, so it gives no pulse.
- R7: While reset is applied, `irq_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | CPU clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_async_i | input | 1 | Slow tick, asynchronous to clk_i; each rising edge advances the counter |
| tap_we_i | input | 1 | Tap-index write strobe |
| tap_wdata_i | input | TAP_W | New tap index (selects counter bit) |
| irq_o | output | 1 | One-cycle interrupt pulse per rising edge of the selected bit |

## Verification
The bench builds the block with CNT_W = 8 and so TAP_W = 3, keeping the default two-stage synchronizer. With an 8-bit count, a full wrap takes only 256 ticks. That puts the rollover, and a rising edge of the top bit straight from reset, within a short run. Every tap from 0 to 7 can also be reached through the 3-bit write port.

// File: rtl/ptimer_pkg.sv
package ptimer_pkg;
  localparam int unsigned DefCntW  = 16;
  localparam int unsigned DefSyncN = 2;
endpackage

// File: rtl/ptimer_tick_sync.sv
module ptimer_tick_sync #(
  parameter int unsigned SYNC_N = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_async_i,
  output logic step_o
);
  logic [SYNC_N-1:0] sync_q, sync_d;
  logic              last_q, last_d;

  always_comb begin
    sync_d = {sync_q[SYNC_N-2:0], tick_async_i};
    last_d = sync_q[SYNC_N-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      last_q <= last_d;
    end
  end

  assign step_o = sync_q[SYNC_N-1] & ~last_q;

  p_step_single_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o |=> !step_o);
endmodule

// File: rtl/ptimer_counter.sv
module ptimer_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb cnt_d = cnt_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (step_i) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  p_cnt_step_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cnt_q) |-> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));
  p_cnt_wrap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((&$past(cnt_q)) && !$stable(cnt_q)) |-> (cnt_q == '0));
endmodule

// File: rtl/ptimer_tap_edge.sv
module ptimer_tap_edge #(
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned TAP_W     = 4,
  parameter int unsigned RESET_TAP = CNT_W - 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             tap_we_i,
  input  logic [TAP_W-1:0] tap_wdata_i,
  output logic             irq_o
);
  logic [TAP_W-1:0] tap_q;
  logic             hist_q, hist_d;
  logic             irq_q, irq_d;
  logic             sel_bit;

  assign sel_bit = cnt_i[tap_q];

  always_comb begin
    hist_d = tap_we_i ? 1'b1 : sel_bit;
    irq_d  = sel_bit & ~hist_q & ~tap_we_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       tap_q <= TAP_W'(RESET_TAP);
    else if (tap_we_i) tap_q <= tap_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q <= 1'b1;
      irq_q  <= 1'b0;
    end else begin
      hist_q <= hist_d;
      irq_q  <= irq_d;
    end
  end

  assign irq_o = irq_q;

  p_irq_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |=> !irq_q);
  p_irq_on_high_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |-> sel_bit);
  p_tap_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tap_we_i |=> !irq_q);
endmodule

// File: rtl/ptimer_irq.sv
module ptimer_irq
  import ptimer_pkg::*;
#(
  parameter int unsigned CNT_W  = DefCntW,
  parameter int unsigned SYNC_N = DefSyncN,
  localparam int unsigned TAP_W = $clog2(CNT_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_async_i,
  input  logic             tap_we_i,
  input  logic [TAP_W-1:0] tap_wdata_i,
  output logic             irq_o
);
  logic [1:0]       rst_sync_q;
  logic             rst_n;
  logic             step;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= '0;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  ptimer_tick_sync #(.SYNC_N(SYNC_N)) u_sync (
    .clk_i        (clk_i),
    .rst_ni       (rst_n),
    .tick_async_i (tick_async_i),
    .step_o       (step)
  );

  ptimer_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .step_i (step),
    .cnt_o  (cnt)
  );

  ptimer_tap_edge #(
    .CNT_W     (CNT_W),
    .TAP_W     (TAP_W),
    .RESET_TAP (CNT_W - 1)
  ) u_edge (
    .clk_i       (clk_i),
    .rst_ni      (rst_n),
    .cnt_i       (cnt),
    .tap_we_i    (tap_we_i),
    .tap_wdata_i (tap_wdata_i),
    .irq_o       (irq_o)
  );

  p_irq_reset_r7: assert property (@(posedge clk_i)
    !rst_n |-> !irq_o);
endmodule

// File: tb/ptimer_irq_tb.sv
module ptimer_irq_tb;
  localparam int unsigned CW = 8;
  localparam int unsigned TW = 3;
  localparam int NV = 8;
  localparam int V_TAP [NV] = '{0, 2, 1, 3, 5, 4, 7, 0};
  localparam int V_N   [NV] = '{10, 16, 9, 20, 40, 30, 140, 3};
  localparam int V_EXP [NV] = '{5, 2, 2, 1, 0, 1, 1, 1};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic we = 1'b0;
  logic [TW-1:0] wdata = '0;
  logic irq;

  int n_run = 0;
  int n_fail = 0;
  int pulses = 0;
  int wide = 0;
  logic irq_prev = 1'b0;
  int snap;

  always #4 clk = ~clk;

  ptimer_irq #(.CNT_W(CW)) u_dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .tick_async_i (tick),
    .tap_we_i     (we),
    .tap_wdata_i  (wdata),
    .irq_o        (irq)
  );

  always @(negedge clk) begin
    if (irq === 1'b1) pulses++;
    if (irq === 1'b1 && irq_prev === 1'b1) wide++;
    irq_prev = irq;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic write_tap(input int t);
    @(negedge clk);
    we = 1'b1;
    wdata = TW'(t);
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic do_tick(input int hold);
    tick = 1'b1;
    repeat (hold) @(negedge clk);
    tick = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic settle();
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    check(irq == 1'b0, "R7 in reset", int'(irq), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2: default tap is bit 7 -> first pulse at count 128
    snap = pulses;
    for (int i = 0; i < 127; i++) do_tick(4);
    settle();
    check(pulses - snap == 0, "R2 default tap before 128", pulses - snap, 0);
    snap = pulses;
    do_tick(4);
    settle();
    check(pulses - snap == 1, "R2 default tap at 128", pulses - snap, 1);

    // R7 / R1: reset again, counter back to 0
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(irq == 1'b0, "R7 second reset", int'(irq), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R4 / R6: vector walk (vector 6 wraps the count through 255 -> 0)
    for (int v = 0; v < NV; v++) begin
      write_tap(V_TAP[v]);
      snap = pulses;
      for (int i = 0; i < V_N[v]; i++) do_tick(4);
      settle();
      check(pulses - snap == V_EXP[v], (v == 6) ? "R6 wrap vector" : "R4 vector",
            pulses - snap, V_EXP[v]);
    end

    // R5: count is 12; tap0 bit is 0, tap2 and tap3 bits are 1
    snap = pulses;
    write_tap(2);
    repeat (10) @(negedge clk);
    check(pulses - snap == 0, "R5 tap change 0->2", pulses - snap, 0);
    snap = pulses;
    write_tap(3);
    repeat (10) @(negedge clk);
    check(pulses - snap == 0, "R5 tap change 2->3", pulses - snap, 0);

    // R1: a long-held tick counts once (12 -> 13 -> 14 on tap 0)
    write_tap(0);
    snap = pulses;
    do_tick(40);
    settle();
    check(pulses - snap == 1, "R1 long tick to 13", pulses - snap, 1);
    snap = pulses;
    do_tick(40);
    settle();
    check(pulses - snap == 0, "R1 long tick to 14", pulses - snap, 0);

    check(wide == 0, "R3 single-cycle pulse", wide, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule